// File: doc/BRIEF.md
# Per-Layer Dynamic Fixed-Point Quantizer

This block turns a stream of 24-bit signed fixed-point samples, each with 16 fraction bits, into 8-bit codes. The binary point of those codes is chosen separately for each network layer. Each layer is handled in two passes.

In the calibration pass every accepted sample updates a running maximum and a running minimum. When the layer is closed, the block picks the smallest number of integer bits that covers that range. One bit of the code is the two's-complement sign, and the remaining bits up to seven are fraction bits.

In the conversion pass each sample is rescaled by an arithmetic shift. It is rounded half away from zero and clipped to the code range. Any clipping sets a sticky flag that stays up until the next layer opens. The chosen integer-bit count is visible on a port, so software can attach the layer's scale to its codes.

Top module: `dfx_layer_quant`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `int_bits` is 0 and `overflow` is 0.
- R2: A sample accepted while `mode_cal` is 1 produces no output code. It widens the layer's recorded maximum and minimum. Both start at zero when a layer opens.
- R3: The cycle after `layer_end` is sampled high, `in_ready` is 0 for exactly one cycle and then returns to 1.
- R4: After that not-ready cycle, `int_bits` holds the smallest I in 0..7 for which the recorded maximum is below 2^I and the recorded minimum is at least -2^I. Values are in real units, with input value = raw / 65536. A layer with no calibration samples yields 0.
- R5: A `layer_start` pulse discards the previous layer's maximum and minimum and clears `overflow`.
- R6: A sample accepted while `mode_cal` is 0 yields `out_valid` on the next cycle. `out_code` then equals round(raw / 65536 × 2^(7 − int_bits)), rounded half away from zero, as 8-bit two's complement.
- R7: A rounded result above 127 gives 127, and one below −128 gives −128. Either case sets `overflow`, which stays at 1 until the next `layer_start`. Exactly −128 does not saturate.
- R8: `int_bits` changes only at the end of the not-ready cycle that follows `layer_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cal | input | 1 | 1 = calibrate, 0 = convert |
| layer_start | input | 1 | Pulse: open a new layer |
| layer_end | input | 1 | Pulse: close calibration and fix the integer-bit count |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 24 | Signed input, 16 fraction bits |
| in_ready | output | 1 | Input can be accepted |
| out_valid | output | 1 | Output code valid |
| out_code | output | 8 | Signed 8-bit dynamic fixed-point code |
| int_bits | output | 3 | Integer bits of the current layer's code |
| overflow | output | 1 | Sticky saturation flag |

## Verification
Three layers are calibrated, each with a different range:
- One centred near ±1.5, which selects one integer bit.
- One that stays below 0.25 after a wider previous layer, which shows that the old statistics were dropped.
- One near ±127, which uses all seven integer bits.

An empty layer is also closed, to confirm the zero default. Conversion samples are chosen to fall exactly on rounding ties of both signs, so half-away rounding is told apart from truncation and from round-to-even. Other samples are chosen to just exceed the positive limit, to land exactly on −128, and to just pass −128, so the saturation edge and the sticky flag are separated on both sides.

// File: rtl/dfx_layer_quant.sv
module dfx_layer_quant #(
  parameter int IN_W    = 24,
  parameter int IN_FRAC = 16,
  parameter int OUT_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_cal,
  input  logic                    layer_start,
  input  logic                    layer_end,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_code,
  output logic [$clog2(OUT_W)-1:0] int_bits,
  output logic                    overflow
);
  localparam int IB_W = $clog2(OUT_W);
  localparam int FMAX = OUT_W - 1;
  localparam int MW   = IN_W + 1;
  localparam int PMAX = (1 << (OUT_W - 1)) - 1;
  localparam int NMAX = 1 << (OUT_W - 1);

  logic signed [IN_W-1:0] hi_q, lo_q, hi_base, lo_base;
  logic                   fin_q;
  logic [IB_W-1:0]        ib_q, ib_next;
  logic [IN_W-1:0]        span;
  logic [MW-1:0]          mag, rnd;
  logic                   neg, sat;
  logic [OUT_W-1:0]       code;

  wire take = in_valid && in_ready;
  wire cal  = take && mode_cal;
  wire conv = take && !mode_cal;

  assign in_ready = !fin_q;
  assign int_bits = ib_q;
  assign hi_base  = layer_start ? '0 : hi_q;
  assign lo_base  = layer_start ? '0 : lo_q;
  assign span     = hi_q | (lo_q[IN_W-1] ? ~lo_q : '0);

  always_comb begin
    int lead;
    int t;
    lead = -1;
    for (int i = 0; i < IN_W; i++)
      if (span[i]) lead = i;
    t = lead + 1 - IN_FRAC;
    if (t < 0) t = 0;
    if (t > FMAX) t = FMAX;
    ib_next = IB_W'(t);
  end

  always_comb begin
    int sh;
    sh  = IN_FRAC - (FMAX - int'(ib_q));
    neg = in_data[IN_W-1];
    mag = neg ? MW'(-$signed({in_data[IN_W-1], in_data})) : MW'({1'b0, in_data});
    rnd = (mag + (MW'(1) << (sh - 1))) >> sh;
    if (!neg) begin
      sat  = rnd > MW'(PMAX);
      code = sat ? OUT_W'(PMAX) : rnd[OUT_W-1:0];
    end else begin
      sat  = rnd > MW'(NMAX);
      code = sat ? OUT_W'(NMAX) : OUT_W'(-rnd[OUT_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      fin_q     <= 1'b0;
      ib_q      <= '0;
      out_valid <= 1'b0;
      out_code  <= '0;
      overflow  <= 1'b0;
    end else begin
      fin_q <= layer_end;
      if (cal) begin
        hi_q <= (in_data > hi_base) ? in_data : hi_base;
        lo_q <= (in_data < lo_base) ? in_data : lo_base;
      end else if (layer_start) begin
        hi_q <= '0;
        lo_q <= '0;
      end
      if (fin_q) ib_q <= ib_next;
      out_valid <= conv;
      if (conv) out_code <= code;
      overflow <= (layer_start ? 1'b0 : overflow) | (conv && sat);
    end
  end
endmodule

// File: rtl/dfx_layer_quant_chk.sv
module dfx_layer_quant_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_cal,
  input logic       layer_start,
  input logic       layer_end,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [2:0] int_bits,
  input logic       overflow
);
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n) layer_end |=> !in_ready); // R3
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n) (!in_ready && !layer_end) |=> in_ready); // R3
  AST_CAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && mode_cal) |=> !out_valid); // R2
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && !mode_cal) |=> out_valid); // R6
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (layer_start && !(in_valid && in_ready && !mode_cal)) |=> !overflow); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overflow && !layer_start) |=> overflow); // R7
  AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) in_ready |=> $stable(int_bits)); // R8
endmodule

bind dfx_layer_quant dfx_layer_quant_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_cal(mode_cal), .layer_start(layer_start),
  .layer_end(layer_end), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .int_bits(int_bits), .overflow(overflow)
);

// File: tb/dfx_layer_quant_tb.sv
module dfx_layer_quant_tb;
  logic clk = 0, rst_n = 0;
  logic mode_cal = 1, layer_start = 0, layer_end = 0, in_valid = 0;
  logic signed [23:0] in_data = '0;
  logic in_ready, out_valid, overflow;
  logic [7:0] out_code;
  logic [2:0] int_bits;

  int checks = 0, fails = 0;
  int exp_q[$];
  real m_hi, m_lo;
  int m_ib;
  bit m_ovf;

  always #2 clk = ~clk;

  dfx_layer_quant u_dut (
    .clk(clk), .rst_n(rst_n), .mode_cal(mode_cal), .layer_start(layer_start),
    .layer_end(layer_end), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_code(out_code),
    .int_bits(int_bits), .overflow(overflow)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_ib(real hi, real lo);
    for (int i = 0; i < 8; i++)
      if (hi < 2.0 ** i && lo >= -(2.0 ** i)) return i;
    return 7;
  endfunction

  function automatic int model_code(int raw, int ib, output bit sat);
    real v, r;
    v = raw / 65536.0 * (2.0 ** (7 - ib));
    r = (v >= 0.0) ? $floor(v + 0.5) : -$floor(-v + 0.5);
    sat = 0;
    if (r > 127.0) begin r = 127.0; sat = 1; end
    if (r < -128.0) begin r = -128.0; sat = 1; end
    return int'(r);
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: actual unexpected code %0d expected no output", $signed(out_code));
      end else begin
        chk("R6/R7 code", $signed(out_code), exp_q.pop_front());
      end
    end
  end

  task automatic open_layer();
    layer_start = 1;
    m_hi = 0.0; m_lo = 0.0; m_ovf = 0;
    @(negedge clk);
    layer_start = 0;
  endtask

  task automatic send(int raw);
    bit s;
    in_valid = 1;
    in_data = 24'(raw);
    if (mode_cal) begin
      if (raw / 65536.0 > m_hi) m_hi = raw / 65536.0;
      if (raw / 65536.0 < m_lo) m_lo = raw / 65536.0;
    end else begin
      exp_q.push_back(model_code(raw, m_ib, s));
      if (s) m_ovf = 1;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic close_layer();
    layer_end = 1;
    @(negedge clk);
    layer_end = 0;
    chk("R3 ready low", in_ready, 0);
    @(negedge clk);
    chk("R3 ready back", in_ready, 1);
    m_ib = model_ib(m_hi, m_lo);
    chk("R4 int_bits", int_bits, m_ib);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    chk("R6 queue empty", exp_q.size(), 0);
  endtask

  initial begin
    #10000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_ib = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 int_bits", int_bits, 0);
    chk("R1 overflow", overflow, 0);
    rst_n = 1;
    @(negedge clk);

    // Layer A: range +-1.5 -> 1 integer bit (R2 no output, R4)
    mode_cal = 1;
    open_layer();
    send(98304); send(-49152); send(1000);
    drain();
    close_layer();
    mode_cal = 0;
    send(98304);   // 96
    send(-49152);  // -48
    send(512);     // tie 0.5 -> 1
    send(-512);    // tie -0.5 -> -1
    send(1536);    // tie 1.5 -> 2
    chk("R7 no overflow yet", overflow, 0);
    send(131071);  // rounds to 128 -> 127
    @(negedge clk);
    chk("R7 overflow set", overflow, 1);
    send(100);
    chk("R7 overflow sticky", overflow, 1);
    chk("R8 int_bits held", int_bits, 1);
    drain();

    // Layer B: small range; old stats discarded (R5)
    mode_cal = 1;
    open_layer();
    chk("R5 overflow cleared", overflow, 0);
    send(16384); send(-1000);
    close_layer();
    chk("R5 stats cleared", int_bits, 0);
    mode_cal = 0;
    send(-65536);  // exactly -128
    @(negedge clk);
    chk("R7 -128 not saturated", overflow, 0);
    send(-66000);  // below -128
    @(negedge clk);
    chk("R7 negative saturation", overflow, 1);
    send(300);     // 0.5859 -> 1 code
    drain();

    // Layer C: wide range -> 7 integer bits
    mode_cal = 1;
    open_layer();
    send(6553600); send(-8355840);
    close_layer();
    mode_cal = 0;
    send(6570000); // 100.25 -> 100
    send(163840);  // 2.5 -> 3
    send(-163840); // -2.5 -> -3
    send(-8388608);// -128
    chk("R8 int_bits held", int_bits, 7);
    drain();
    chk("R7 overflow model", overflow, int'(m_ovf));

    // Empty layer -> 0
    mode_cal = 1;
    open_layer();
    close_layer();
    chk("R4 empty layer", int_bits, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule